// File: doc/BRIEF.md
# PLL Divider Search Engine

This block finds the reference divider M, feedback multiplier N and power-of-two post divider P that bring a pixel-clock PLL closest to a requested output frequency. All frequencies enter as unsigned fixed-point MHz values with 16 fractional bits. After a one-cycle start pulse the engine clamps the request into the range the PLL can reach and then walks every (P, M) pair. It works out a rounded N for each pair, rejects the pair if any limit is broken, and keeps the pair with the smallest frequency error.

A second input widens the search. It allows a post divider of 32, lowers the smallest M to 4 and moves the phase-comparator window. When the walk ends, the engine raises a one-cycle done pulse. It presents M, N, P as log2 code, the packed divider word and the achieved frequency, and a valid flag that is low when no pair passed.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy_o, done_o and valid_o are low and m_o, n_o, p_enc_o, setting_o and fout_o are zero.
- R2: The lower bound is vco_min_i shifted right by 4, or by 5 when ext_range_i is high (floor). A request below this bound is raised to it.
- R3: A request above pclk_max_i is lowered to pclk_max_i. This upper clamp is applied after the lower one, so pclk_max_i wins when the two conflict.
- R4: P is swept over 1, 2, 4, 8 and 16, and also 32 when ext_range_i is high. A P is used only when vco_min_i ≤ clamped request × P ≤ vco_max_i, with both limits inclusive.
- R5: M is swept upward from 7 (from 4 when ext_range_i is high) to 14. An M is used only when lo·M ≤ fref_i ≤ hi·M. The window is lo = 1.0 and hi = 2.0 MHz in the standard mode, and lo = 111411/65536 and hi = 419430/65536 MHz in the extended mode.
- R6: N = floor((request·P·M + floor(fref_i/2)) / fref_i). A pair whose N lies outside 1 to 255 is rejected.
- R7: The achieved frequency is floor(fref_i·N/M) shifted right by log2 P, and the error is its absolute difference from the clamped request. The sweep runs P ascending in the outer loop and M ascending in the inner loop. A later pair replaces the stored best only when its error is strictly smaller.
- R8: p_enc_o is log2 P (1→0, 2→1, 4→2, 8→3, 16→4, 32→5). setting_o holds P code in bits 18:16, N in bits 15:8 and M in bits 7:0. fout_o is the achieved frequency of the best pair.
- R9: When no pair passes every check, valid_o is low and m_o, n_o, p_enc_o, setting_o and fout_o are zero.
- R10: start_i is accepted only while busy_o is low, and busy_o is high from the next cycle until the result is presented. done_o pulses for exactly one cycle per accepted start, and results stay unchanged between done pulses. A start_i pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| ext_range_i | input | 1 | Extended search: P up to 32, M from 4, wide window |
| req_i | input | 32 | Requested frequency, MHz Q16.16 |
| fref_i | input | 32 | Reference frequency, MHz Q16.16 |
| vco_min_i | input | 32 | Lowest VCO frequency, MHz Q16.16 |
| vco_max_i | input | 32 | Highest VCO frequency, MHz Q16.16 |
| pclk_max_i | input | 32 | Highest allowed output frequency, MHz Q16.16 |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle result pulse |
| valid_o | output | 1 | A passing pair was found |
| m_o | output | 8 | Best M |
| n_o | output | 8 | Best N |
| p_enc_o | output | 3 | Best P as log2 code |
| setting_o | output | 19 | Packed {P code, N, M} |
| fout_o | output | 32 | Achieved frequency, MHz Q16.16 |

## Verification
The bench builds the engine with its default parameters: Q16.16 frequencies, M limits of 7 or 4 to 14, post-divider exponents up to 4 or 5, and both phase-comparator windows. Because the extended option is an input port, a single build reaches both sweeps, including the P=32 branch and the M values below 7. Its reference frequencies, VCO limits and requests are chosen so that each clamp, the window edge at M=14, a sweep with no survivor and the conflict between the two clamps are all reached. A start pulse sent mid-search covers the ignore rule.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PCHK,
    S_MCHK,
    S_NDIV,
    S_FDIV,
    S_FIN
  } srch_state_e;

endpackage

// File: rtl/pll_req_clamp.sv
module pll_req_clamp #(
  parameter int W       = 32,
  parameter int PSH_STD = 4,
  parameter int PSH_EXT = 5
) (
  input  logic         ext_i,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] vco_min_i,
  input  logic [W-1:0] pclk_max_i,
  output logic [W-1:0] req_o
);

  logic [W-1:0] floor_lo;
  logic [W-1:0] raised;

  always_comb begin
    floor_lo = ext_i ? (vco_min_i >> PSH_EXT) : (vco_min_i >> PSH_STD);
    raised   = (req_i < floor_lo) ? floor_lo : req_i;
    req_o    = (raised > pclk_max_i) ? pclk_max_i : raised;
  end

endmodule

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int NUMW = 42,
  parameter int DENW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [NUMW-1:0] num_i,
  input  logic [DENW-1:0] den_i,
  output logic            done_o,
  output logic [NUMW-1:0] quo_o
);

  localparam int CW = $clog2(NUMW + 1);

  logic [DENW-1:0] rem_q, rem_d;
  logic [DENW-1:0] den_q, den_d;
  logic [NUMW-1:0] dvd_q, dvd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            run_q, run_d;
  logic            done_q, done_d;
  logic [DENW:0]   trial;
  logic            ge;

  always_comb begin
    trial  = {rem_q, dvd_q[NUMW-1]};
    ge     = (trial >= {1'b0, den_q});
    rem_d  = rem_q;
    den_d  = den_q;
    dvd_d  = dvd_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (start_i && !run_q) begin
      rem_d = '0;
      dvd_d = num_i;
      den_d = den_i;
      cnt_d = CW'(NUMW);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = ge ? DENW'(trial - {1'b0, den_q}) : trial[DENW-1:0];
      dvd_d = {dvd_q[NUMW-2:0], ge};
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      dvd_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      dvd_q  <= dvd_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign quo_o  = dvd_q;

endmodule

// File: rtl/pll_best_keep.sv
module pll_best_keep #(
  parameter int EW  = 42,
  parameter int MW  = 4,
  parameter int NW  = 8,
  parameter int PEW = 3,
  parameter int W   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           upd_i,
  input  logic [EW-1:0]  err_i,
  input  logic [MW-1:0]  m_i,
  input  logic [NW-1:0]  n_i,
  input  logic [PEW-1:0] s_i,
  input  logic [W-1:0]   ach_i,
  output logic           found_o,
  output logic [MW-1:0]  m_o,
  output logic [NW-1:0]  n_o,
  output logic [PEW-1:0] s_o,
  output logic [W-1:0]   ach_o
);

  logic           found_q, found_d;
  logic [EW-1:0]  err_q, err_d;
  logic [MW-1:0]  m_q, m_d;
  logic [NW-1:0]  n_q, n_d;
  logic [PEW-1:0] s_q, s_d;
  logic [W-1:0]   ach_q, ach_d;
  logic           take;

  always_comb begin
    take    = upd_i && (!found_q || (err_i < err_q));
    found_d = found_q;
    err_d   = err_q;
    m_d     = m_q;
    n_d     = n_q;
    s_d     = s_q;
    ach_d   = ach_q;
    if (clr_i) begin
      found_d = 1'b0;
      err_d   = '0;
      m_d     = '0;
      n_d     = '0;
      s_d     = '0;
      ach_d   = '0;
    end else if (take) begin
      found_d = 1'b1;
      err_d   = err_i;
      m_d     = m_i;
      n_d     = n_i;
      s_d     = s_i;
      ach_d   = ach_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      err_q   <= '0;
      m_q     <= '0;
      n_q     <= '0;
      s_q     <= '0;
      ach_q   <= '0;
    end else begin
      found_q <= found_d;
      err_q   <= err_d;
      m_q     <= m_d;
      n_q     <= n_d;
      s_q     <= s_d;
      ach_q   <= ach_d;
    end
  end

  assign found_o = found_q;
  assign m_o     = m_q;
  assign n_o     = n_q;
  assign s_o     = s_q;
  assign ach_o   = ach_q;

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int           W          = 32,
  parameter int           NW         = 8,
  parameter int           N_MAX      = 255,
  parameter int           M_MIN_STD  = 7,
  parameter int           M_MIN_EXT  = 4,
  parameter int           M_MAX      = 14,
  parameter int           PSH_STD    = 4,
  parameter int           PSH_EXT    = 5,
  parameter logic [W-1:0] PFD_LO_STD = 32'd65536,
  parameter logic [W-1:0] PFD_HI_STD = 32'd131072,
  parameter logic [W-1:0] PFD_LO_EXT = 32'd111411,
  parameter logic [W-1:0] PFD_HI_EXT = 32'd419430
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ext_range_i,
  input  logic [W-1:0]  req_i,
  input  logic [W-1:0]  fref_i,
  input  logic [W-1:0]  vco_min_i,
  input  logic [W-1:0]  vco_max_i,
  input  logic [W-1:0]  pclk_max_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          valid_o,
  output logic [7:0]    m_o,
  output logic [NW-1:0] n_o,
  output logic [2:0]    p_enc_o,
  output logic [18:0]   setting_o,
  output logic [W-1:0]  fout_o
);

  localparam int MOW  = 8;
  localparam int MW   = $clog2(M_MAX + 2);
  localparam int PEW  = $clog2(PSH_EXT + 1);
  localparam int SW   = $clog2(PSH_EXT + 2);
  localparam int FVW  = W + PSH_EXT;
  localparam int NA   = FVW + MW + 1;
  localparam int NB   = W + NW;
  localparam int NUMW = (NA > NB) ? NA : NB;
  localparam int WINW = W + MW;

  srch_state_e state_q, state_d;

  logic          ext_q;
  logic [W-1:0]  req_q, fref_q, vmin_q, vmax_q;
  logic [SW-1:0] s_q, s_d;
  logic [MW-1:0] m_q, m_d;
  logic [NW-1:0] n_q, n_d;
  logic          cap_en;

  logic [W-1:0]    req_clamped;
  logic [SW-1:0]   smax;
  logic [MW-1:0]   mmin;
  logic [W-1:0]    pfd_lo, pfd_hi;
  logic [FVW-1:0]  fvco;
  logic            vco_ok;
  logic [WINW-1:0] lo_m, hi_m;
  logic            win_ok;
  logic [NUMW-1:0] n_num, f_num;
  logic [NUMW-1:0] ach, err, req_ext;
  logic            n_ok;

  logic            div_start, div_done;
  logic [NUMW-1:0] div_num, div_quo;
  logic [W-1:0]    div_den;

  logic            trk_clr, trk_vld, trk_found;
  logic [MW-1:0]   trk_m;
  logic [NW-1:0]   trk_n;
  logic [PEW-1:0]  trk_s;
  logic [W-1:0]    trk_ach;

  logic            res_ld;
  logic            done_q, done_d;
  logic            valid_q, valid_d;
  logic [MOW-1:0]  mres_q, mres_d;
  logic [NW-1:0]   nres_q, nres_d;
  logic [2:0]      pres_q, pres_d;
  logic [W-1:0]    fres_q, fres_d;

  pll_req_clamp #(
    .W       (W),
    .PSH_STD (PSH_STD),
    .PSH_EXT (PSH_EXT)
  ) u_clamp (
    .ext_i      (ext_range_i),
    .req_i      (req_i),
    .vco_min_i  (vco_min_i),
    .pclk_max_i (pclk_max_i),
    .req_o      (req_clamped)
  );

  pll_seq_div #(
    .NUMW (NUMW),
    .DENW (W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (div_start),
    .num_i   (div_num),
    .den_i   (div_den),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  pll_best_keep #(
    .EW  (NUMW),
    .MW  (MW),
    .NW  (NW),
    .PEW (PEW),
    .W   (W)
  ) u_best (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (trk_clr),
    .upd_i   (trk_vld),
    .err_i   (err),
    .m_i     (m_q),
    .n_i     (n_q),
    .s_i     (s_q[PEW-1:0]),
    .ach_i   (ach[W-1:0]),
    .found_o (trk_found),
    .m_o     (trk_m),
    .n_o     (trk_n),
    .s_o     (trk_s),
    .ach_o   (trk_ach)
  );

  // Candidate arithmetic for the current (P, M) pair
  always_comb begin
    smax    = ext_q ? SW'(PSH_EXT) : SW'(PSH_STD);
    mmin    = ext_q ? MW'(M_MIN_EXT) : MW'(M_MIN_STD);
    pfd_lo  = ext_q ? PFD_LO_EXT : PFD_LO_STD;
    pfd_hi  = ext_q ? PFD_HI_EXT : PFD_HI_STD;
    fvco    = FVW'(req_q) << s_q;
    vco_ok  = (fvco >= FVW'(vmin_q)) && (fvco <= FVW'(vmax_q));
    lo_m    = WINW'(pfd_lo) * WINW'(m_q);
    hi_m    = WINW'(pfd_hi) * WINW'(m_q);
    win_ok  = (lo_m <= WINW'(fref_q)) && (WINW'(fref_q) <= hi_m);
    n_num   = NUMW'(fvco) * NUMW'(m_q) + NUMW'(fref_q >> 1);
    f_num   = NUMW'(fref_q) * NUMW'(div_quo[NW-1:0]);
    n_ok    = (div_quo >= NUMW'(1)) && (div_quo <= NUMW'(N_MAX));
    ach     = div_quo >> s_q;
    req_ext = NUMW'(req_q);
    err     = (req_ext >= ach) ? (req_ext - ach) : (ach - req_ext);
  end

  // Sweep control, next state
  always_comb begin
    state_d   = state_q;
    s_d       = s_q;
    m_d       = m_q;
    n_d       = n_q;
    div_start = 1'b0;
    div_num   = n_num;
    div_den   = fref_q;
    trk_clr   = 1'b0;
    trk_vld   = 1'b0;
    res_ld    = 1'b0;
    cap_en    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          trk_clr = 1'b1;
          s_d     = '0;
          state_d = S_PCHK;
        end
      end
      S_PCHK: begin
        if (s_q > smax) begin
          state_d = S_FIN;
        end else if (vco_ok) begin
          m_d     = mmin;
          state_d = S_MCHK;
        end else begin
          s_d = s_q + SW'(1);
        end
      end
      S_MCHK: begin
        if (m_q > MW'(M_MAX)) begin
          s_d     = s_q + SW'(1);
          state_d = S_PCHK;
        end else if (win_ok) begin
          div_start = 1'b1;
          state_d   = S_NDIV;
        end else begin
          m_d = m_q + MW'(1);
        end
      end
      S_NDIV: begin
        if (div_done) begin
          if (n_ok) begin
            n_d       = div_quo[NW-1:0];
            div_start = 1'b1;
            div_num   = f_num;
            div_den   = W'(m_q);
            state_d   = S_FDIV;
          end else begin
            m_d     = m_q + MW'(1);
            state_d = S_MCHK;
          end
        end
      end
      S_FDIV: begin
        if (div_done) begin
          trk_vld = 1'b1;
          m_d     = m_q + MW'(1);
          state_d = S_MCHK;
        end
      end
      S_FIN: begin
        res_ld  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // Result next state
  always_comb begin
    done_d  = res_ld;
    valid_d = valid_q;
    mres_d  = mres_q;
    nres_d  = nres_q;
    pres_d  = pres_q;
    fres_d  = fres_q;
    if (res_ld) begin
      valid_d = trk_found;
      mres_d  = trk_found ? MOW'(trk_m) : '0;
      nres_d  = trk_found ? trk_n : '0;
      pres_d  = trk_found ? 3'(trk_s) : '0;
      fres_d  = trk_found ? trk_ach : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      s_q     <= '0;
      m_q     <= '0;
      n_q     <= '0;
    end else begin
      state_q <= state_d;
      s_q     <= s_d;
      m_q     <= m_d;
      n_q     <= n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      req_q  <= '0;
      fref_q <= '0;
      vmin_q <= '0;
      vmax_q <= '0;
    end else if (cap_en) begin
      ext_q  <= ext_range_i;
      req_q  <= req_clamped;
      fref_q <= fref_i;
      vmin_q <= vco_min_i;
      vmax_q <= vco_max_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      mres_q  <= '0;
      nres_q  <= '0;
      pres_q  <= '0;
      fres_q  <= '0;
    end else begin
      done_q  <= done_d;
      valid_q <= valid_d;
      mres_q  <= mres_d;
      nres_q  <= nres_d;
      pres_q  <= pres_d;
      fres_q  <= fres_d;
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign valid_o   = valid_q;
  assign m_o       = mres_q;
  assign n_o       = nres_q;
  assign p_enc_o   = pres_q;
  assign setting_o = {pres_q, nres_q, mres_q};
  assign fout_o    = fres_q;

endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk #(
  parameter int W       = 32,
  parameter int NW      = 8,
  parameter int M_LOW   = 4,
  parameter int M_MAX   = 14,
  parameter int PSH_EXT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          valid_o,
  input logic [7:0]    m_o,
  input logic [NW-1:0] n_o,
  input logic [2:0]    p_enc_o,
  input logic [18:0]   setting_o,
  input logic [W-1:0]  fout_o
);

  // R10: a result pulse lasts a single cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: an accepted start makes the engine busy on the next cycle
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R10: the engine is idle when the result is presented
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: results change only together with the result pulse
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(setting_o) && $stable(valid_o) && $stable(fout_o)));

  // R6: a reported N never lies outside 1..255
  p_n_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (n_o != '0));

  // R5: a reported M lies inside the widest sweep
  p_m_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((m_o >= 8'(M_LOW)) && (m_o <= 8'(M_MAX))));

  // R8: the P code never exceeds the largest exponent
  p_p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (p_enc_o <= 3'(PSH_EXT)));

  // R9: an empty search reports zeros
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ((setting_o == '0) && (fout_o == '0)));

endmodule

bind pll_div_search pll_search_chk #(
  .W       (W),
  .NW      (NW),
  .M_LOW   (M_MIN_EXT),
  .M_MAX   (M_MAX),
  .PSH_EXT (PSH_EXT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .valid_o   (valid_o),
  .m_o       (m_o),
  .n_o       (n_o),
  .p_enc_o   (p_enc_o),
  .setting_o (setting_o),
  .fout_o    (fout_o)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;

  localparam longint LO_STD = 65536;
  localparam longint HI_STD = 131072;
  localparam longint LO_EXT = 111411;
  localparam longint HI_EXT = 419430;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        ext_range_i = 1'b0;
  logic [31:0] req_i = '0, fref_i = '0, vco_min_i = '0, vco_max_i = '0, pclk_max_i = '0;
  logic        busy_o, done_o, valid_o;
  logic [7:0]  m_o, n_o;
  logic [2:0]  p_enc_o;
  logic [18:0] setting_o;
  logic [31:0] fout_o;

  always #5 clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_range_i(ext_range_i),
    .req_i(req_i), .fref_i(fref_i), .vco_min_i(vco_min_i), .vco_max_i(vco_max_i),
    .pclk_max_i(pclk_max_i), .busy_o(busy_o), .done_o(done_o), .valid_o(valid_o),
    .m_o(m_o), .n_o(n_o), .p_enc_o(p_enc_o), .setting_o(setting_o), .fout_o(fout_o)
  );

  typedef struct {
    string  tag;
    bit     valid;
    longint m, n, p, fout;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  task automatic chk(string tag, string what, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic longint fx(real mhz);
    return longint'(mhz * 65536.0);
  endfunction

  // Independent model of the search rules
  function automatic exp_t model(string tag, bit ext, longint req, longint fref,
                                 longint vmin, longint vmax, longint pmax);
    exp_t   e;
    longint r, lw, lo, hi, fv, n, a, er, best;
    int     smax, mmin;
    e.tag = tag; e.valid = 0; e.m = 0; e.n = 0; e.p = 0; e.fout = 0;
    best = 0;
    smax = ext ? 5 : 4;
    mmin = ext ? 4 : 7;
    lo   = ext ? LO_EXT : LO_STD;
    hi   = ext ? HI_EXT : HI_STD;
    lw   = vmin >> smax;
    r    = req;
    if (r < lw) r = lw;
    if (r > pmax) r = pmax;
    for (int s = 0; s <= smax; s++) begin
      fv = r << s;
      if (fv < vmin || fv > vmax) continue;
      for (int m = mmin; m <= 14; m++) begin
        if (lo * m > fref || hi * m < fref) continue;
        n = (fv * m + fref / 2) / fref;
        if (n < 1 || n > 255) continue;
        a  = ((fref * n) / m) >> s;
        er = (r >= a) ? r - a : a - r;
        if (!e.valid || er < best) begin
          e.valid = 1; best = er; e.m = m; e.n = n; e.p = s; e.fout = a;
        end
      end
    end
    return e;
  endfunction

  task automatic drive(bit ext, real req, real fref, real vmin, real vmax, real pmax);
    ext_range_i = ext;
    req_i       = 32'(fx(req));
    fref_i      = 32'(fx(fref));
    vco_min_i   = 32'(fx(vmin));
    vco_max_i   = 32'(fx(vmax));
    pclk_max_i  = 32'(fx(pmax));
  endtask

  task automatic run_case(string tag, bit ext, real req, real fref, real vmin,
                          real vmax, real pmax);
    q.push_back(model(tag, ext, fx(req), fx(fref), fx(vmin), fx(vmax), fx(pmax)));
    @(negedge clk);
    drive(ext, req, fref, vmin, vmax, pmax);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  // Monitor: pop expected result on each done pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        chk("R10", "unexpected done", 1, 0);
      end else begin
        e = q.pop_front();
        chk(e.tag, "valid", longint'(valid_o), longint'(e.valid));
        chk(e.tag, "m", longint'(m_o), e.m);
        chk(e.tag, "n", longint'(n_o), e.n);
        chk({e.tag, " R8"}, "p_enc", longint'(p_enc_o), e.p);
        chk({e.tag, " R8"}, "setting", longint'(setting_o), (e.p << 16) | (e.n << 8) | e.m);
        chk(e.tag, "fout", longint'(fout_o), e.fout);
        chk("R10", "busy at done", longint'(busy_o), 0);
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busy", longint'(busy_o), 0);
    chk("R1", "done", longint'(done_o), 0);
    chk("R1", "valid", longint'(valid_o), 0);
    chk("R1", "setting", longint'(setting_o), 0);
    chk("R1", "fout", longint'(fout_o), 0);

    // R4 R5 R6 R7: standard sweep at several requests
    run_case("R7", 1'b0, 25.175, 13.5, 128.0, 350.0, 350.0);
    run_case("R6", 1'b0, 65.0, 13.5, 128.0, 350.0, 350.0);
    run_case("R4", 1'b0, 108.0, 13.5, 128.0, 350.0, 350.0);
    run_case("R5", 1'b0, 9.0, 14.0, 128.0, 350.0, 350.0);
    // R2: request raised to vco_min/16
    run_case("R2", 1'b0, 1.0, 13.5, 128.0, 350.0, 350.0);
    // R3: request lowered to the maximum clock
    run_case("R3", 1'b0, 500.0, 13.5, 128.0, 350.0, 350.0);
    // R3: upper clamp wins over lower one, leaving no usable P
    run_case("R3", 1'b0, 2.0, 13.5, 128.0, 350.0, 6.0);
    // R9: reference outside every window
    run_case("R9", 1'b0, 50.0, 40.0, 128.0, 350.0, 350.0);
    // R9: VCO range unreachable by any P
    run_case("R9", 1'b0, 200.0, 13.5, 300.0, 310.0, 350.0);
    // R4 R5: extended sweep needing P=32 and small M
    run_case("R4", 1'b1, 5.0, 27.0, 128.0, 350.0, 350.0);
    run_case("R5", 1'b1, 74.25, 27.0, 128.0, 350.0, 350.0);
    // R2: extended lower clamp at vco_min/32
    run_case("R2", 1'b1, 0.5, 27.0, 128.0, 350.0, 350.0);

    // R10: a start pulse during a search is ignored
    q.push_back(model("R10", 1'b0, fx(65.0), fx(13.5), fx(128.0), fx(350.0), fx(350.0)));
    @(negedge clk);
    drive(1'b0, 65.0, 13.5, 128.0, 350.0, 350.0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10", "busy mid-search", longint'(busy_o), 1);
    drive(1'b1, 5.0, 27.0, 128.0, 350.0, 350.0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (200) @(negedge clk);
    chk("R10", "idle after one result", longint'(busy_o), 0);

    summary();
    $finish;
  end

endmodule